// File: doc/BRIEF.md
# Activity-Based Automatic Power-Down Controller

This block watches a vector of monitored signals (dedicated inputs, bidirectional pins, the clock pin and internal feedback) and decides when a surrounding logic array may be put to sleep. Each sampling-clock edge compares the monitored vector with the value seen at the previous edge. When no difference has been seen for a programmed number of edges, the controller freezes the output vector in a hold register and raises a sleep flag.

The outputs never go invalid. While the block is awake the live output vector passes straight through. While asleep the held copy is driven instead. Any change on any monitored bit wakes the block. For a programmable number of cycles after waking, the held copy stays selected and a wake-latency flag is raised. This models the slower first response after leaving sleep. After that the live outputs pass through again. All timing is counted in sampling-clock cycles. No analog power gating is modelled.

Top module: `pd_activity_ctrl`

## Requirements
- R1: During and right after the synchronous active-low reset, `sleep_o` and `wake_busy_o` are 0. The value of `mon_i` sampled during reset is the baseline, so the first edge after reset does not count as a change.
- R2: An edge "sees a change" when `mon_i` at that edge differs from `mon_i` at the previous edge. Let E be the last edge that saw a change. `sleep_o` is 0 after edges E through E+IDLE_CYC-1 and becomes 1 after edge E+IDLE_CYC. After reset, the reset release counts as E.
- R3: At the edge where `sleep_o` rises, `out_o` takes the value that `live_i` had at that edge.
- R4: While `sleep_o` stays 1, `out_o` does not change, whatever `live_i` does.
- R5: A change in any single bit of `mon_i` while asleep clears `sleep_o` after the edge that samples the change.
- R6: After the wake edge, `wake_busy_o` is 1 for exactly WAKE_LAT cycles (none if WAKE_LAT is 0). During those cycles `out_o` keeps the held value.
- R7: Whenever `sleep_o` and `wake_busy_o` are both 0, `out_o` equals `live_i` in the same cycle (combinational pass-through).
- R8: If changes keep arriving no more than IDLE_CYC edges apart, `sleep_o` stays 0.
- R9: `sleep_o` and `wake_busy_o` are never both 1. After waking with no further change, the block sleeps again IDLE_CYC edges after the wake edge and holds the new `live_i` value from that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Synchronous reset, active low |
| mon_i | input | MON_W | Monitored activity vector |
| live_i | input | OUT_W | Live output vector from the logic array |
| out_o | output | OUT_W | Output vector: live while awake, held while asleep or waking |
| sleep_o | output | 1 | Power-down indication |
| wake_busy_o | output | 1 | High during the extra wake-up latency cycles |

## Verification
The hardest situation to reach from the ports is the exact sleep boundary. The sleep flag must stay low through IDLE_CYC-1 quiet edges and rise on the next one. The same boundary must also hold right after a wake, while the wake latency is still running. The bench counts edges from the edge that sees each change. It sweeps quiet gaps from zero up to past the threshold and wakes the block once from each monitored bit position. It then lets the block fall back asleep with a fresh live value, so that the wake latency, the re-entry into sleep and the recapture of the held value all occur in one timed sequence.

// File: rtl/pd_pkg.sv
// Package: shared types for the activity-based power-down controller.
// Assumes: nothing beyond IEEE 1800-2017.
package pd_pkg;

    // Operating mode of the controller
    typedef enum logic [1:0] {
        PD_AWAKE  = 2'd0,
        PD_ASLEEP = 2'd1,
        PD_WAKING = 2'd2
    } pd_mode_e;

endpackage

// File: rtl/pd_edge_det.sv
// Module: pd_edge_det
// Compares each sample of the monitored vector with the previous one and
// flags any difference. Assumes a synchronous active-low reset. The sample
// taken during reset becomes the baseline, so reset release is not a change.
module pd_edge_det #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] sample_i,
    output logic         change_o
);

    logic [W-1:0] prev_q;

    // Keep the previous sample (the baseline while in reset)
    always_ff @(posedge clk) begin
        prev_q <= sample_i;
    end

    // Any differing bit counts as activity, except while in reset
    always_comb begin
        change_o = rst_n && (|(sample_i ^ prev_q));
    end

endmodule

// File: rtl/pd_idle_timer.sv
// Module: pd_idle_timer
// Counts quiet edges since the last change and saturates at LIMIT. Reports
// combinationally when the count reaches LIMIT at the coming edge.
// Assumes LIMIT >= 1.
module pd_idle_timer #(
    parameter int LIMIT = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic change_i,
    output logic full_nxt_o
);

    localparam int CW = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] CNT_MAX = CW'(LIMIT);
    localparam logic [CW-1:0] CNT_PRE = CW'(LIMIT - 1);

    logic [CW-1:0] cnt_q;

    // Clear on activity, otherwise count up to the saturation point
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (change_i) begin
            cnt_q <= '0;
        end else if (cnt_q != CNT_MAX) begin
            cnt_q <= cnt_q + CW'(1);
        end
    end

    // The count reaches the limit at the next edge when quiet now
    always_comb begin
        full_nxt_o = !change_i && (cnt_q >= CNT_PRE);
    end

endmodule

// File: rtl/pd_mode_fsm.sv
// Module: pd_mode_fsm
// Sequences the awake, asleep and waking modes. It requests a capture of the
// outputs on every entry into sleep and times the wake latency.
// Assumes WAKE_LAT >= 0 and inputs from pd_edge_det and pd_idle_timer.
module pd_mode_fsm
    import pd_pkg::*;
#(
    parameter int WAKE_LAT = 1
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     change_i,
    input  logic     idle_full_i,
    output pd_mode_e mode_o,
    output logic     capture_o
);

    localparam int WW = (WAKE_LAT < 1) ? 1 : $clog2(WAKE_LAT + 1);
    localparam logic [WW-1:0] LAT_LOAD = WW'(WAKE_LAT);

    pd_mode_e      mode_q, mode_nxt;
    logic [WW-1:0] wcnt_q, wcnt_nxt;

    // Next-mode and wake-counter decisions
    always_comb begin
        mode_nxt  = mode_q;
        wcnt_nxt  = wcnt_q;
        capture_o = 1'b0;
        case (mode_q)
            PD_AWAKE: begin
                if (idle_full_i) begin
                    mode_nxt  = PD_ASLEEP;
                    capture_o = 1'b1;
                end
            end
            PD_ASLEEP: begin
                if (change_i) begin
                    if (WAKE_LAT == 0) begin
                        mode_nxt = PD_AWAKE;
                    end else begin
                        mode_nxt = PD_WAKING;
                        wcnt_nxt = LAT_LOAD;
                    end
                end
            end
            PD_WAKING: begin
                if (idle_full_i) begin
                    mode_nxt  = PD_ASLEEP;
                    capture_o = 1'b1;
                    wcnt_nxt  = '0;
                end else if (wcnt_q <= WW'(1)) begin
                    mode_nxt = PD_AWAKE;
                    wcnt_nxt = '0;
                end else begin
                    wcnt_nxt = wcnt_q - WW'(1);
                end
            end
            default: begin
                mode_nxt = PD_AWAKE;
                wcnt_nxt = '0;
            end
        endcase
    end

    // Mode and wake-counter registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= PD_AWAKE;
            wcnt_q <= '0;
        end else begin
            mode_q <= mode_nxt;
            wcnt_q <= wcnt_nxt;
        end
    end

    // Expose the current mode
    always_comb begin
        mode_o = mode_q;
    end

endmodule

// File: rtl/pd_out_hold.sv
// Module: pd_out_hold
// Holds a copy of the live outputs taken on capture and selects between the
// held copy and the live vector. Assumes capture comes from pd_mode_fsm.
module pd_out_hold #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         capture_i,
    input  logic         use_hold_i,
    input  logic [W-1:0] live_i,
    output logic [W-1:0] out_o
);

    logic [W-1:0] hold_q;

    // Load the hold register only on a capture request
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_q <= '0;
        end else if (capture_i) begin
            hold_q <= live_i;
        end
    end

    // Drive the held copy or the live vector
    always_comb begin
        out_o = use_hold_i ? hold_q : live_i;
    end

endmodule

// File: rtl/pd_activity_ctrl.sv
// Module: pd_activity_ctrl (top)
// Activity-based automatic power-down controller. Sleeps after IDLE_CYC quiet
// edges on mon_i and wakes on any change. Outputs are held while asleep and
// for WAKE_LAT cycles after waking. Assumes IDLE_CYC >= 1 and a synchronous
// active-low reset.
module pd_activity_ctrl
    import pd_pkg::*;
#(
    parameter int MON_W    = 8,
    parameter int OUT_W    = 8,
    parameter int IDLE_CYC = 2,
    parameter int WAKE_LAT = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [MON_W-1:0] mon_i,
    input  logic [OUT_W-1:0] live_i,
    output logic [OUT_W-1:0] out_o,
    output logic             sleep_o,
    output logic             wake_busy_o
);

    logic     change;
    logic     idle_full;
    logic     capture;
    pd_mode_e mode;

    pd_edge_det #(.W(MON_W)) u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .sample_i (mon_i),
        .change_o (change)
    );

    pd_idle_timer #(.LIMIT(IDLE_CYC)) u_idle (
        .clk        (clk),
        .rst_n      (rst_n),
        .change_i   (change),
        .full_nxt_o (idle_full)
    );

    pd_mode_fsm #(.WAKE_LAT(WAKE_LAT)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .change_i    (change),
        .idle_full_i (idle_full),
        .mode_o      (mode),
        .capture_o   (capture)
    );

    // Decode the mode flags
    always_comb begin
        sleep_o     = (mode == PD_ASLEEP);
        wake_busy_o = (mode == PD_WAKING);
    end

    pd_out_hold #(.W(OUT_W)) u_hold (
        .clk        (clk),
        .rst_n      (rst_n),
        .capture_i  (capture),
        .use_hold_i (sleep_o || wake_busy_o),
        .live_i     (live_i),
        .out_o      (out_o)
    );

endmodule

// File: rtl/pd_activity_ctrl_chk.sv
// Module: pd_activity_ctrl_chk
// Property checker for pd_activity_ctrl, attached with bind. It only observes
// the top-level ports.
module pd_activity_ctrl_chk #(
    parameter int MON_W    = 8,
    parameter int OUT_W    = 8,
    parameter int WAKE_LAT = 1
) (
    input logic             clk,
    input logic             rst_n,
    input logic [MON_W-1:0] mon_i,
    input logic [OUT_W-1:0] live_i,
    input logic [OUT_W-1:0] out_o,
    input logic             sleep_o,
    input logic             wake_busy_o
);

    p_reset_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!sleep_o && !wake_busy_o));

    p_entry_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sleep_o) |-> ($past(mon_i) == $past(mon_i, 2)));

    p_entry_latch_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sleep_o) |-> (out_o == $past(live_i)));

    p_hold_stable_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (sleep_o && $past(sleep_o)) |-> $stable(out_o));

    p_wake_on_change_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (sleep_o && (mon_i != $past(mon_i))) |=> !sleep_o);

    p_wake_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sleep_o) |-> (wake_busy_o == (WAKE_LAT != 0)));

    p_wake_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        wake_busy_o |-> $stable(out_o));

    p_live_pass_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!sleep_o && !wake_busy_o) |-> (out_o == live_i));

    p_excl_flags_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(sleep_o && wake_busy_o));

endmodule

bind pd_activity_ctrl pd_activity_ctrl_chk #(
    .MON_W    (MON_W),
    .OUT_W    (OUT_W),
    .WAKE_LAT (WAKE_LAT)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .mon_i       (mon_i),
    .live_i      (live_i),
    .out_o       (out_o),
    .sleep_o     (sleep_o),
    .wake_busy_o (wake_busy_o)
);

// File: tb/pd_activity_ctrl_test.sv
// Bench: pd_activity_ctrl_test
// Sweeps quiet-gap lengths and single-bit wake sources on the default
// configuration. Expected values come from edge counting.
module pd_activity_ctrl_test;

    localparam int MW   = 8;
    localparam int OW   = 8;
    localparam int IDLE = 2;
    localparam int WLAT = 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [MW-1:0] mon = 8'h3C;
    logic [OW-1:0] live = 8'h11;
    logic [OW-1:0] out;
    logic          sleep;
    logic          busy;

    int  n_tests = 0;
    int  n_fail = 0;
    bit  done = 1'b0;

    always #5 clk = ~clk;

    pd_activity_ctrl #(
        .MON_W(MW), .OUT_W(OW), .IDLE_CYC(IDLE), .WAKE_LAT(WLAT)
    ) uut (
        .clk(clk), .rst_n(rst_n), .mon_i(mon), .live_i(live),
        .out_o(out), .sleep_o(sleep), .wake_busy_o(busy)
    );

    // Advance one edge and settle away from it
    task automatic step();
        @(posedge clk);
        #1;
    endtask

    // Compare and count
    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0h expected %0h", req, act, exp);
        end
    endtask

    // Let the block fall asleep from any mode
    task automatic settle();
        repeat (IDLE + 1) step();
    endtask

    initial begin
        logic [OW-1:0] held;
        repeat (3) step();
        rst_n = 1'b1;
        // R1: reset state, pass-through
        chk("R1 sleep after reset", {31'd0, sleep}, 0);
        chk("R1 busy after reset", {31'd0, busy}, 0);
        live = 8'h22;
        #1;
        chk("R7 live pass after reset", {24'd0, out}, 32'h22);
        // R1/R2: reset baseline is not a change
        repeat (IDLE - 1) step();
        chk("R1 no early sleep", {31'd0, sleep}, 0);
        step();
        chk("R1 sleep at threshold after reset", {31'd0, sleep}, 1);
        chk("R3 hold after reset entry", {24'd0, out}, 32'h22);

        // R2: sweep quiet gaps after a change
        for (int g = 1; g <= IDLE + 3; g++) begin
            mon = mon + 8'd1;
            for (int s = 1; s <= g; s++) begin
                step();
                chk("R2 sleep vs quiet edges", {31'd0, sleep}, (s - 1 >= IDLE) ? 1 : 0);
            end
        end

        // R3/R4: latch value at entry, stable while asleep
        mon = mon ^ 8'h80;
        for (int s = 1; s <= IDLE; s++) begin
            live = 8'h40 + 8'(s);
            step();
        end
        live = 8'h5A;
        step();
        chk("R3 sleep entry", {31'd0, sleep}, 1);
        chk("R3 latched value", {24'd0, out}, 32'h5A);
        for (int k = 0; k < 16; k++) begin
            live = 8'(k * 37 + 3);
            step();
            chk("R4 held stable", {24'd0, out}, 32'h5A);
        end

        // R5/R6/R7/R9: wake from each bit position
        for (int b = 0; b < MW; b++) begin
            settle();
            held = out;
            mon = mon ^ (8'h01 << b);
            live = 8'hC0 | 8'(b);
            step();
            chk("R5 wake on bit", {31'd0, sleep}, 0);
            chk("R6 busy at wake", {31'd0, busy}, (WLAT > 0) ? 1 : 0);
            chk("R6 hold during wake", {24'd0, out}, {24'd0, held});
            for (int w = 1; w < WLAT; w++) begin
                step();
                chk("R6 busy window", {31'd0, busy}, 1);
                chk("R6 hold in window", {24'd0, out}, {24'd0, held});
            end
            step();
            chk("R6 busy ends", {31'd0, busy}, 0);
            chk("R7 live after wake", {24'd0, out}, {24'd0, live});
            for (int r = WLAT + 1; r < IDLE; r++) step();
            live = 8'hA0 | 8'(b);
            step();
            chk("R9 re-sleep", {31'd0, sleep}, 1);
            chk("R9 busy low asleep", {31'd0, busy}, 0);
            chk("R9 recapture", {24'd0, out}, {24'd0, (8'hA0 | 8'(b))});
        end

        // R8: changes every IDLE edges keep the block awake
        for (int i = 0; i < 30; i++) begin
            if (i % IDLE == 0) mon = mon + 8'd3;
            step();
            chk("R8 stays awake", {31'd0, sleep}, 0);
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule